// File: doc/BRIEF.md
# Buffered PWM Channel Group

Four independent PWM channels, each built around a 16-bit up-counter. A channel counts only on clock cycles where the shared count enable is high and the channel's own start bit is set. Each such cycle is a tick.

On a tick where the counter equals the channel's period register, several things happen at once:
- the counter returns to zero;
- the channel's match flag is raised;
- the staged duty value is copied into a working duty register that software cannot write directly;
- the output is driven high, unless the staged value is zero, in which case it is driven low.

Later in the period, a tick where the counter equals a nonzero working duty value drives the output low for the rest of the period.

Because software only writes the staged value, every period completes with the duty it started with. A staged zero gives a clean low period with no glitch.

Software reaches the period registers, the staged duty registers, the flag register and the start register over a simple word-wide bus. Reads are combinational. Writes take effect at the clock edge.

Top module: `pwm_group`

## Requirements
- R1: After reset, every period and staged-duty register reads 0xFFFF, the flag and start registers read 0, and all outputs are high.
- R2: A channel counter advances only on cycles where countEn is high and the channel's start bit is set. With period value P, matches recur every P+1 ticks, and the first match comes on the (P+1)th tick after start. While no tick occurs, the channel's flag and output do not change.
- R3: A match sets the channel's flag bit. Flag bit i is bit i of the flag register.
- R4: A staged-duty write takes effect only at the next match. The period that is running when the write lands completes with the old value.
- R5: At a match, the output goes low if the value being transferred is 0x0000, and high otherwise. A zero therefore keeps the output low for the whole following period.
- R6: With working duty D, period P and 0 < D < P, the output is high for D+1 ticks per period, starting at the match. If D ≥ P, the output stays high for the whole period.
- R7: A write whose two byte enables are not both set changes no register.
- R8: A flag bit clears only through a write with a 0 in that bit, and only after the bit was read as 1 over the bus. Writing 0 without a prior read leaves the bit set.
- R9: If a match and a clearing write fall in the same cycle, the flag stays set.
- R10: Register map, by word address:
  - 0 to 3: period registers for channels A to D.
  - 4 to 7: staged duty registers for channels A to D.
  - 8: flag register, bits 3:0.
  - 9: start register, bits 3:0.
  - Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Shared count enable for all channels |
| busAddr | input | 4 | Word address |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe; arms flag clearing |
| busByteEn | input | 2 | Byte lane enables; both must be set for a write |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Combinational read data |
| pwmOut | output | 4 | Channel outputs, bit i is channel i |

## Verification
The bench sweeps period values 1 to 6 with every duty value from 0 up to one past the period. In each case it counts high samples over a full period, so any off-by-one in the duty compare, or a missing low for a zero duty, shows up as a wrong count. In the same run it rewrites the staged value just after a match and checks that the current period keeps the old duty. A design that loads the working duty at write time would change that period's count.

With a period of 0, a channel matches on every tick. The bench uses this to attempt a read-then-clear; a design that gives software priority would let the flag drop. Further checks cover the following:
- Half-lane writes, which a careless decoder would accept.
- A clear without a prior read, which a design missing the arming step would honour.
- Channels that are not started, or are held by countEn, which a design with wrong gating would let drift.

// File: rtl/pwm_group_pkg.sv
package pwm_group_pkg;
  parameter int CH_N = 4;
  parameter int WORD_W = 16;
  localparam int LANES = WORD_W / 8;
  localparam int STAT_ADDR = 2 * CH_N;
  localparam int START_ADDR = 2 * CH_N + 1;
  localparam int ADDR_W = $clog2(2 * CH_N + 2);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [CH_N-1:0] ldCycle;
    logic [CH_N-1:0] ldBuffer;
    logic [CH_N-1:0] tick;
    word_t           data;
  } strobe_t;
endpackage

// File: rtl/pwm_group_dp.sv
module pwm_group_dp
  import pwm_group_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  output word_t [CH_N-1:0]      cycleQ,
  output word_t [CH_N-1:0]      bufferQ,
  output logic  [CH_N-1:0]      matchHit,
  output logic  [CH_N-1:0]      pwmOut
);
  for (genvar g = 0; g < CH_N; g++) begin : gCh
    word_t cycleReg, bufferReg, dutyReg, cnt;
    logic  outReg, hit;

    assign hit = stb.tick[g] && (cnt == cycleReg);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cycleReg  <= '1;
        bufferReg <= '1;
        dutyReg   <= '1;
        cnt       <= '0;
        outReg    <= 1'b1;
      end else begin
        if (stb.ldCycle[g])  cycleReg  <= stb.data;
        if (stb.ldBuffer[g]) bufferReg <= stb.data;
        if (stb.tick[g]) begin
          if (hit) begin
            cnt     <= '0;
            dutyReg <= bufferReg;
            outReg  <= |bufferReg;
          end else begin
            cnt <= cnt + 1'b1;
            if ((dutyReg != '0) && (cnt == dutyReg)) outReg <= 1'b0;
          end
        end
      end
    end

    assign cycleQ[g]   = cycleReg;
    assign bufferQ[g]  = bufferReg;
    assign matchHit[g] = hit;
    assign pwmOut[g]   = outReg;
  end
endmodule

// File: rtl/pwm_group_ctl.sv
module pwm_group_ctl
  import pwm_group_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [LANES-1:0]  busByteEn,
  input  word_t             busWdata,
  input  word_t [CH_N-1:0]  cycleQ,
  input  word_t [CH_N-1:0]  bufferQ,
  input  logic  [CH_N-1:0]  matchHit,
  output strobe_t           stb,
  output logic  [CH_N-1:0]  flagQ,
  output word_t             busRdata
);
  logic [CH_N-1:0] startQ, armedQ, clrMask, readArm;
  logic fullWr, statWr, startWr, statRd;

  assign fullWr  = busWrite && (&busByteEn);
  assign statWr  = fullWr && (busAddr == ADDR_W'(STAT_ADDR));
  assign startWr = fullWr && (busAddr == ADDR_W'(START_ADDR));
  assign statRd  = busRead && (busAddr == ADDR_W'(STAT_ADDR));
  assign clrMask = statWr ? (armedQ & ~busWdata[CH_N-1:0]) : '0;
  assign readArm = statRd ? flagQ : '0;

  always_comb begin
    stb.data = busWdata;
    stb.tick = startQ & {CH_N{countEn}};
    for (int i = 0; i < CH_N; i++) begin
      stb.ldCycle[i]  = fullWr && (busAddr == ADDR_W'(i));
      stb.ldBuffer[i] = fullWr && (busAddr == ADDR_W'(CH_N + i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      flagQ  <= '0;
      armedQ <= '0;
    end else begin
      if (startWr) startQ <= busWdata[CH_N-1:0];
      flagQ  <= (flagQ & ~clrMask) | matchHit;
      armedQ <= (armedQ | readArm) & ~clrMask;
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < CH_N; i++) begin
      if (busAddr == ADDR_W'(i))        busRdata = cycleQ[i];
      if (busAddr == ADDR_W'(CH_N + i)) busRdata = bufferQ[i];
    end
    if (busAddr == ADDR_W'(STAT_ADDR))  busRdata = WORD_W'(flagQ);
    if (busAddr == ADDR_W'(START_ADDR)) busRdata = WORD_W'(startQ);
  end
endmodule

// File: rtl/pwm_group.sv
module pwm_group
  import pwm_group_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              countEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [LANES-1:0]  busByteEn,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic [CH_N-1:0]   pwmOut
);
  strobe_t          stb;
  word_t [CH_N-1:0] cycleQ, bufferQ;
  logic  [CH_N-1:0] matchHit, flagQ;

  pwm_group_ctl u_ctl (
    .clk(clk), .rstN(rstN), .countEn(countEn), .busAddr(busAddr),
    .busWrite(busWrite), .busRead(busRead), .busByteEn(busByteEn),
    .busWdata(busWdata), .cycleQ(cycleQ), .bufferQ(bufferQ),
    .matchHit(matchHit), .stb(stb), .flagQ(flagQ), .busRdata(busRdata)
  );

  pwm_group_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cycleQ(cycleQ),
    .bufferQ(bufferQ), .matchHit(matchHit), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_group_chk.sv
module pwm_group_chk
  import pwm_group_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic [LANES-1:0]  busByteEn,
  input logic [WORD_W-1:0] busWdata,
  input logic [CH_N-1:0]   pwmOut,
  input strobe_t           stb,
  input word_t [CH_N-1:0]  cycleQ,
  input word_t [CH_N-1:0]  bufferQ,
  input logic  [CH_N-1:0]  matchHit,
  input logic  [CH_N-1:0]  flagQ
);
  assert_partial_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !(&busByteEn)) |=> ($stable(cycleQ) && $stable(bufferQ)));

  for (genvar g = 0; g < CH_N; g++) begin : gChk
    // Flag set on match; holds against a same-cycle clear (R9)
    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      matchHit[g] |=> flagQ[g]);

    assert_zero_low_R5: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[g] && bufferQ[g] == '0) |=> !pwmOut[g]);

    assert_nonzero_high_R5: assert property (@(posedge clk) disable iff (!rstN)
      (matchHit[g] && bufferQ[g] != '0) |=> pwmOut[g]);

    assert_fall_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwmOut[g]) |-> $past(stb.tick[g]));

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
      !stb.tick[g] |=> $stable(pwmOut[g]));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagQ[g]) |-> $past(busWrite && (&busByteEn) &&
                                busAddr == ADDR_W'(STAT_ADDR) && !busWdata[g]));
  end
endmodule

bind pwm_group pwm_group_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busByteEn(busByteEn), .busWdata(busWdata), .pwmOut(pwmOut), .stb(stb),
  .cycleQ(cycleQ), .bufferQ(bufferQ), .matchHit(matchHit), .flagQ(flagQ)
);

// File: tb/pwm_group_test.sv
module pwm_group_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic        busRead = 1'b0;
  logic [1:0]  busByteEn = 2'b11;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFails = 0;

  pwm_group uut (
    .clk(clk), .rstN(rstN), .countEn(countEn), .busAddr(busAddr),
    .busWrite(busWrite), .busRead(busRead), .busByteEn(busByteEn),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; countEn = 1'b0; busWrite = 1'b0; busRead = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input int a, input int d, input logic [1:0] be = 2'b11);
    busAddr = 4'(a); busWdata = 16'(d); busByteEn = be; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busByteEn = 2'b11;
  endtask

  task automatic regRead(input int a, output int d);
    busAddr = 4'(a); busRead = 1'b1;
    #1 d = int'(busRdata);
    @(negedge clk);
    busRead = 1'b0;
  endtask

  task automatic peek(input int a, output int d);
    busAddr = 4'(a);
    #1 d = int'(busRdata);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int v;
    doReset();
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      regRead(i, v); check("R1", v, 16'hFFFF);
    end
    regRead(8, v); check("R1", v, 0);
    regRead(9, v); check("R1", v, 0);
    check("R1", int'(pwmOut), 4'hF);

    // R10 map and R7 lane gating
    for (int i = 0; i < 8; i++) regWrite(i, 16'h1000 + i * 16'h0111);
    for (int i = 0; i < 8; i++) begin
      regRead(i, v); check("R10", v, 16'h1000 + i * 16'h0111);
    end
    regRead(12, v); check("R10", v, 0);
    regWrite(5, 16'hBEEF, 2'b01);
    regWrite(5, 16'hBEEF, 2'b10);
    regWrite(2, 16'hBEEF, 2'b00);
    regRead(5, v); check("R7", v, 16'h1000 + 5 * 16'h0111);
    regRead(2, v); check("R7", v, 16'h1000 + 2 * 16'h0111);
    regWrite(9, 1, 2'b01);
    regRead(9, v); check("R7", v, 0);

    // R2 gating: channel 0 period 3, channel 1 period 0 but not started
    doReset();
    regWrite(0, 3); regWrite(1, 0); regWrite(9, 1);
    repeat (20) @(negedge clk);
    peek(8, v); check("R2", v, 0);
    countEn = 1'b1;
    repeat (3) @(negedge clk);
    peek(8, v); check("R2", v & 1, 0);
    @(negedge clk);
    peek(8, v); check("R2", v & 1, 1);
    check("R2", v & 2, 0);
    check("R2", int'(pwmOut[1]), 1);

    // R8 clearing protocol
    countEn = 1'b0;
    regWrite(8, 0);
    peek(8, v); check("R8", v & 1, 1);
    regRead(8, v);
    regWrite(8, 1);
    peek(8, v); check("R8", v & 1, 1);
    regWrite(8, 0);
    peek(8, v); check("R8", v & 1, 0);

    // R9 set beats clear: period 0 matches every tick
    doReset();
    regWrite(2, 0); regWrite(9, 4); countEn = 1'b1;
    repeat (2) @(negedge clk);
    regRead(8, v); check("R9", v & 4, 4);
    regWrite(8, 0);
    peek(8, v); check("R9", v & 4, 4);

    // R4/R5/R6 sweep over period 1..6 and duty 0..P+1
    for (int p = 1; p <= 6; p++) begin
      for (int d = 0; d <= p + 1; d++) begin
        int ch, d2, hi1, hi2, exp1, exp2, found;
        ch = p % 4;
        d2 = (d + 2) % (p + 2);
        doReset();
        regWrite(ch, p); regWrite(4 + ch, d);
        busAddr = 4'd8;
        countEn = 1'b1;
        regWrite(9, 1 << ch);
        busAddr = 4'd8;
        found = 0;
        for (int w = 0; w < 40 && found == 0; w++) begin
          @(negedge clk); #1;
          if (busRdata[ch]) found = 1;
        end
        check("R3", found, 1);
        hi1 = 0; hi2 = 0;
        for (int k = 0; k < 2 * (p + 1); k++) begin
          if (k > 0) begin @(negedge clk); #1; end
          if (k < p + 1) hi1 += int'(pwmOut[ch]); else hi2 += int'(pwmOut[ch]);
          if (k == 0) begin
            busAddr = 4'(4 + ch); busWdata = 16'(d2); busWrite = 1'b1;
          end else busWrite = 1'b0;
        end
        exp1 = (d == 0) ? 0 : (d >= p) ? p + 1 : d + 1;
        exp2 = (d2 == 0) ? 0 : (d2 >= p) ? p + 1 : d2 + 1;
        check(d == 0 ? "R5" : "R6", hi1, exp1);
        check("R4", hi2, exp2);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule